// File: doc/BRIEF.md
# Switchable Frame CRC Generator and Checker

This block sits between a byte-wide frame FIFO and a serial channel and guards every frame with a cyclic redundancy check. On the transmit side it passes payload bytes through. After the last payload byte it can add one or two check bytes and move the end-of-frame marker onto the final check byte. On the receive side it can treat the trailing one or two bytes of each frame as the check value. Those bytes are never passed downstream. A sticky error flag reports a mismatch.

An 8-bit configuration register selects the mode for each frame. The options are 8-bit or 16-bit check width, most- or least-significant-bit-first shifting, and a plain or HDLC-style variant. Transmit generation and receive checking are enabled separately. The register value is captured when a frame's first byte is accepted, so a write made during a frame applies to the following frame. All four data streams use valid/ready handshakes with a last marker.

Top module: `frame_crc_unit`

## Requirements
- R1: After reset the configuration register reads 0x0C: transmit append (bit 2) and receive check (bit 3) on, 16-bit, LSB-first, plain variant. The error flag is low and neither output stream is valid.
- R2: Writes to bits 7, 1 and 0 are dropped and those bits always read 0; bits 6..2 read back exactly as written.
- R3: With bit 2 set, the check bytes follow the last payload byte, and only the final check byte carries last. With bit 2 clear, the transmit output equals the payload, with last on its final byte.
- R4: In 16-bit mode (bit 4 = 0) the generator polynomial is 0x1021. In the plain variant the preset is 0x0000, there is no final inversion, and the high byte goes first. The ASCII string "123456789" with MSB-first order gives bytes 0x31 then 0xC3.
- R5: In 8-bit mode (bit 4 = 1) the polynomial is 0x07 and one check byte is used. For "123456789", MSB-first and plain, that byte is 0xF4.
- R6: Bit 6 = 1 shifts each byte's bit 7 into the register first; bit 6 = 0 shifts bit 0 first.
- R7: Bit 5 = 1 selects the HDLC-style variant: all-ones preset, complemented result and low byte first. For "123456789", MSB-first and 16-bit, the bytes are 0x4E then 0xD6.
- R8: With bit 3 set, a frame whose trailing bytes match the check value comes out as its payload only, with last on the final payload byte, and the error flag stays low.
- R9: A receive mismatch sets the error flag. The flag stays set until a status-clear pulse arrives or the next receive frame's first byte is accepted.
- R10: A receive frame shorter than the check length sets the error flag and forwards no bytes.
- R11: With bit 3 clear, every received byte, the trailing ones included, is forwarded with its last marker and no error is raised.
- R12: Configuration is captured at the first byte of each frame. A write made during a frame shows at once on the read port but changes only later frames.
- R13: While an output is valid and its ready is low, its data and last hold steady. No byte is lost or repeated under back-pressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data |
| stat_clr | input | 1 | Status write pulse; clears the error flag |
| crc_err | output | 1 | Sticky receive check error |
| tx_in_valid | input | 1 | Transmit payload byte valid |
| tx_in_data | input | 8 | Transmit payload byte |
| tx_in_last | input | 1 | Last payload byte of the frame |
| tx_in_ready | output | 1 | Transmit payload accepted |
| tx_out_valid | output | 1 | Channel byte valid |
| tx_out_data | output | 8 | Channel byte |
| tx_out_last | output | 1 | Final byte of the outgoing frame |
| tx_out_ready | input | 1 | Channel ready |
| rx_in_valid | input | 1 | Received byte valid |
| rx_in_data | input | 8 | Received byte |
| rx_in_last | input | 1 | Final received byte of the frame |
| rx_in_ready | output | 1 | Received byte accepted |
| rx_out_valid | output | 1 | Checked byte valid toward the FIFO |
| rx_out_data | output | 8 | Checked byte |
| rx_out_last | output | 1 | Final payload byte of the frame |
| rx_out_ready | input | 1 | FIFO ready |

## Verification
A wrong running check value stays hidden during the payload. It shows on the transmit side in the first appended byte, one cycle after the last payload byte is taken. On the receive side it shows as a raised error flag one cycle after the frame's last byte. A fault in the receive delay line shows up as a lost, duplicated or misplaced last marker, or as check bytes leaking to the FIFO, within the same frame. A fault in when configuration is captured shows up only in the frame that follows a mid-frame write. Frames are therefore looped from the transmit output into the receive input across every mode, with back-pressure on some of them.

// File: rtl/fcrc_pkg.sv
package fcrc_pkg;

    localparam int CB_MSB  = 6;
    localparam int CB_HDLC = 5;
    localparam int CB_W8   = 4;
    localparam int CB_RXEN = 3;
    localparam int CB_TXEN = 2;

    localparam logic [7:0]  CFG_WMASK = 8'h7C;
    localparam logic [15:0] POLY16    = 16'h1021;
    localparam logic [7:0]  POLY8     = 8'h07;

    function automatic logic [1:0] crc_len(input logic [7:0] cfg);
        return cfg[CB_W8] ? 2'd1 : 2'd2;
    endfunction

    function automatic logic [15:0] crc_preset(input logic [7:0] cfg);
        if (!cfg[CB_HDLC]) return 16'h0000;
        return cfg[CB_W8] ? 16'h00FF : 16'hFFFF;
    endfunction

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b,
                                             input logic [7:0] cfg);
        logic [15:0] r;
        logic        bit_in;
        logic        fb;
        r = c;
        for (int i = 0; i < 8; i++) begin
            bit_in = cfg[CB_MSB] ? b[7-i] : b[i];
            if (cfg[CB_W8]) begin
                fb = r[7] ^ bit_in;
                r  = {8'h00, r[6:0], 1'b0} ^ (fb ? {8'h00, POLY8} : 16'h0000);
            end else begin
                fb = r[15] ^ bit_in;
                r  = {r[14:0], 1'b0} ^ (fb ? POLY16 : 16'h0000);
            end
        end
        return r;
    endfunction

    function automatic logic [15:0] crc_final(input logic [15:0] c, input logic [7:0] cfg);
        if (!cfg[CB_HDLC]) return c;
        return cfg[CB_W8] ? {8'h00, ~c[7:0]} : ~c;
    endfunction

    // byte of the finished value sent at position 0 or 1 after the payload
    function automatic logic [7:0] crc_byte(input logic [15:0] fin, input logic [7:0] cfg,
                                            input logic second);
        if (cfg[CB_W8]) return fin[7:0];
        if (cfg[CB_HDLC]) return second ? fin[15:8] : fin[7:0];
        return second ? fin[7:0] : fin[15:8];
    endfunction

endpackage

// File: rtl/fcrc_tx.sv
module fcrc_tx
    import fcrc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] cfg,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_last,
    output logic       in_ready,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_last,
    input  logic       out_ready
);

    typedef enum logic {TX_PASS, TX_APPEND} tx_phase_e;

    typedef struct packed {
        tx_phase_e   phase;
        logic        in_frame;
        logic [7:0]  fcfg;
        logic [15:0] crc;
        logic        idx;
        logic        ov;
        logic [7:0]  od;
        logic        ol;
    } tx_state_t;

    localparam tx_state_t TX_RESET = '{phase: TX_PASS, default: '0};

    tx_state_t q, d;

    logic can_emit;
    assign can_emit = !q.ov || out_ready;
    assign in_ready = (q.phase == TX_PASS) && can_emit;

    always_comb begin
        logic [7:0]  cfg_e;
        logic [15:0] crc_b;
        logic [15:0] fin;
        logic        acc;
        d     = q;
        cfg_e = q.in_frame ? q.fcfg : cfg;
        crc_b = q.in_frame ? q.crc : crc_preset(cfg);
        fin   = crc_final(q.crc, q.fcfg);
        acc   = in_valid && in_ready;
        if (q.ov && out_ready) d.ov = 1'b0;
        if (acc) begin
            if (!q.in_frame) begin
                d.in_frame = 1'b1;
                d.fcfg     = cfg;
            end
            d.crc = crc_step(crc_b, in_data, cfg_e);
            d.ov  = 1'b1;
            d.od  = in_data;
            d.ol  = 1'b0;
            if (in_last) begin
                if (cfg_e[CB_TXEN]) begin
                    d.phase = TX_APPEND;
                    d.idx   = 1'b0;
                end else begin
                    d.ol       = 1'b1;
                    d.in_frame = 1'b0;
                end
            end
        end else if (q.phase == TX_APPEND && can_emit) begin
            d.ov = 1'b1;
            d.od = crc_byte(fin, q.fcfg, q.idx);
            d.ol = ({1'b0, q.idx} == crc_len(q.fcfg) - 2'd1);
            if (d.ol) begin
                d.phase    = TX_PASS;
                d.in_frame = 1'b0;
            end else begin
                d.idx = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= TX_RESET;
        else        q <= d;
    end

    assign out_valid = q.ov;
    assign out_data  = q.od;
    assign out_last  = q.ol;

endmodule

// File: rtl/fcrc_rx.sv
module fcrc_rx
    import fcrc_pkg::*;
#(
    parameter int HOLD = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] cfg,
    input  logic       err_clr,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_last,
    output logic       in_ready,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_last,
    input  logic       out_ready,
    output logic       crc_err
);

    localparam int FW = $clog2(HOLD);

    typedef enum logic {RX_RUN, RX_FLUSH} rx_phase_e;

    typedef struct packed {
        rx_phase_e             phase;
        logic                  in_frame;
        logic [7:0]            fcfg;
        logic [15:0]           crc;
        logic [HOLD-1:0][7:0]  sh;
        logic [FW-1:0]         fill;
        logic                  ov;
        logic [7:0]            od;
        logic                  ol;
        logic                  err;
    } rx_state_t;

    localparam rx_state_t RX_RESET = '{phase: RX_RUN, default: '0};

    rx_state_t q, d;

    logic can_emit;
    assign can_emit = !q.ov || out_ready;
    assign in_ready = (q.phase == RX_RUN) && can_emit;

    always_comb begin
        logic [7:0]    cfg_e;
        logic [FW-1:0] n_crc;
        logic [FW-1:0] depth;
        logic [FW-1:0] fill_b;
        logic [15:0]   crc_b;
        logic [15:0]   fin;
        logic [7:0]    mv;
        logic          acc;
        logic          bad;
        d      = q;
        cfg_e  = q.in_frame ? q.fcfg : cfg;
        n_crc  = cfg_e[CB_RXEN] ? FW'(crc_len(cfg_e)) : '0;
        depth  = n_crc + FW'(1);
        fill_b = q.in_frame ? q.fill : '0;
        crc_b  = q.in_frame ? q.crc : crc_preset(cfg);
        fin    = crc_final(q.crc, cfg_e);
        mv     = (n_crc == '0) ? in_data : q.sh[n_crc - FW'(1)];
        acc    = in_valid && in_ready;
        bad    = 1'b0;
        if (q.ov && out_ready) d.ov = 1'b0;
        if (err_clr) d.err = 1'b0;
        if (acc) begin
            if (!q.in_frame) begin
                d.in_frame = 1'b1;
                d.fcfg     = cfg;
                d.err      = 1'b0;
            end
            // oldest payload byte leaves only once a newer one replaces it
            if (fill_b == depth) begin
                d.ov = 1'b1;
                d.od = q.sh[n_crc];
                d.ol = 1'b0;
            end
            d.crc  = (fill_b >= n_crc) ? crc_step(crc_b, mv, cfg_e) : crc_b;
            d.sh   = {q.sh[HOLD-2:0], in_data};
            d.fill = (fill_b == depth) ? depth : fill_b + FW'(1);
            if (in_last) d.phase = RX_FLUSH;
        end else if (q.phase == RX_FLUSH && can_emit) begin
            if (q.fill == depth) begin
                d.ov = 1'b1;
                d.od = q.sh[n_crc];
                d.ol = 1'b1;
            end
            if (n_crc == FW'(2))
                bad = (q.sh[1] != crc_byte(fin, cfg_e, 1'b0)) ||
                      (q.sh[0] != crc_byte(fin, cfg_e, 1'b1));
            else if (n_crc == FW'(1))
                bad = (q.sh[0] != crc_byte(fin, cfg_e, 1'b0));
            if (n_crc != '0 && q.fill < n_crc) bad = 1'b1;
            if (bad) d.err = 1'b1;
            d.phase    = RX_RUN;
            d.in_frame = 1'b0;
            d.fill     = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RX_RESET;
        else        q <= d;
    end

    assign out_valid = q.ov;
    assign out_data  = q.od;
    assign out_last  = q.ol;
    assign crc_err   = q.err;

endmodule

// File: rtl/frame_crc_unit.sv
module frame_crc_unit
    import fcrc_pkg::*;
#(
    parameter logic [7:0] CFG_RESET = 8'h0C
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    input  logic       stat_clr,
    output logic       crc_err,
    input  logic       tx_in_valid,
    input  logic [7:0] tx_in_data,
    input  logic       tx_in_last,
    output logic       tx_in_ready,
    output logic       tx_out_valid,
    output logic [7:0] tx_out_data,
    output logic       tx_out_last,
    input  logic       tx_out_ready,
    input  logic       rx_in_valid,
    input  logic [7:0] rx_in_data,
    input  logic       rx_in_last,
    output logic       rx_in_ready,
    output logic       rx_out_valid,
    output logic [7:0] rx_out_data,
    output logic       rx_out_last,
    input  logic       rx_out_ready
);

    typedef struct packed {
        logic [7:0] cfg;
    } top_state_t;

    top_state_t q, d;

    always_comb begin
        d = q;
        if (cfg_we) d.cfg = cfg_wdata & CFG_WMASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q.cfg <= CFG_RESET & CFG_WMASK;
        else        q <= d;
    end

    assign cfg_rdata = q.cfg;

    fcrc_tx u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (q.cfg),
        .in_valid  (tx_in_valid),
        .in_data   (tx_in_data),
        .in_last   (tx_in_last),
        .in_ready  (tx_in_ready),
        .out_valid (tx_out_valid),
        .out_data  (tx_out_data),
        .out_last  (tx_out_last),
        .out_ready (tx_out_ready)
    );

    fcrc_rx #(.HOLD(4)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (q.cfg),
        .err_clr   (stat_clr),
        .in_valid  (rx_in_valid),
        .in_data   (rx_in_data),
        .in_last   (rx_in_last),
        .in_ready  (rx_in_ready),
        .out_valid (rx_out_valid),
        .out_data  (rx_out_data),
        .out_last  (rx_out_last),
        .out_ready (rx_out_ready),
        .crc_err   (crc_err)
    );

endmodule

// File: rtl/fcrc_checker.sv
module fcrc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_we,
    input logic [7:0] cfg_wdata,
    input logic [7:0] cfg_rdata,
    input logic       stat_clr,
    input logic       crc_err,
    input logic       rx_in_valid,
    input logic       rx_in_ready,
    input logic       tx_out_valid,
    input logic [7:0] tx_out_data,
    input logic       tx_out_last,
    input logic       tx_out_ready,
    input logic       rx_out_valid,
    input logic [7:0] rx_out_data,
    input logic       rx_out_last,
    input logic       rx_out_ready
);

    // R2
    cfg_wmask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> cfg_rdata == ($past(cfg_wdata) & 8'h7C));

    // R13
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_out_valid && !tx_out_ready |=>
            tx_out_valid && $stable(tx_out_data) && $stable(tx_out_last));

    // R13
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_out_valid && !rx_out_ready |=>
            rx_out_valid && $stable(rx_out_data) && $stable(rx_out_last));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err && !stat_clr && !(rx_in_valid && rx_in_ready) |=> crc_err);

    // R9
    err_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_err) |-> $past(!rx_in_ready));

endmodule

bind frame_crc_unit fcrc_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_wdata    (cfg_wdata),
    .cfg_rdata    (cfg_rdata),
    .stat_clr     (stat_clr),
    .crc_err      (crc_err),
    .rx_in_valid  (rx_in_valid),
    .rx_in_ready  (rx_in_ready),
    .tx_out_valid (tx_out_valid),
    .tx_out_data  (tx_out_data),
    .tx_out_last  (tx_out_last),
    .tx_out_ready (tx_out_ready),
    .rx_out_valid (rx_out_valid),
    .rx_out_data  (rx_out_data),
    .rx_out_last  (rx_out_last),
    .rx_out_ready (rx_out_ready)
);

// File: tb/tb_frame_crc_unit.sv
module tb_frame_crc_unit;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       stat_clr = 1'b0;
    logic       crc_err;
    logic       tx_in_valid = 1'b0;
    logic [7:0] tx_in_data = '0;
    logic       tx_in_last = 1'b0;
    logic       tx_in_ready;
    logic       tx_out_valid;
    logic [7:0] tx_out_data;
    logic       tx_out_last;
    logic       tx_out_ready;
    logic       rx_in_valid = 1'b0;
    logic [7:0] rx_in_data = '0;
    logic       rx_in_last = 1'b0;
    logic       rx_in_ready;
    logic       rx_out_valid;
    logic [7:0] rx_out_data;
    logic       rx_out_last;
    logic       rx_out_ready;

    frame_crc_unit dut (.*);

    int total = 0;
    int bad = 0;

    logic [7:0] pay  [0:15];
    logic [7:0] ex   [0:19];
    int         ex_n;
    logic [7:0] rxin [0:19];
    logic [7:0] txc  [0:63];
    logic       txl  [0:63];
    int         txc_n = 0;
    logic [7:0] rxc  [0:63];
    logic       rxl  [0:63];
    int         rxc_n = 0;
    logic       bp = 1'b0;

    typedef struct packed {
        logic [7:0]  cfg;
        logic [2:0]  len;
        logic [31:0] data;
        logic        bp;
    } vec_t;

    localparam vec_t VECS [0:7] = '{
        '{cfg: 8'h0C, len: 3'd3, data: 32'hA1B2C300, bp: 1'b0},
        '{cfg: 8'h4C, len: 3'd4, data: 32'hDEADBEEF, bp: 1'b1},
        '{cfg: 8'h1C, len: 3'd2, data: 32'h55AA0000, bp: 1'b0},
        '{cfg: 8'h5C, len: 3'd1, data: 32'h80000000, bp: 1'b1},
        '{cfg: 8'h2C, len: 3'd3, data: 32'h01020300, bp: 1'b0},
        '{cfg: 8'h7C, len: 3'd4, data: 32'hFF00FF00, bp: 1'b1},
        '{cfg: 8'h3C, len: 3'd2, data: 32'h12340000, bp: 1'b0},
        '{cfg: 8'h6C, len: 3'd1, data: 32'h7E000000, bp: 1'b1}
    };

    // ready drivers: steady high, or toggling every cycle under back-pressure
    initial begin
        tx_out_ready = 1'b1;
        rx_out_ready = 1'b1;
        forever begin
            @(posedge clk);
            #1;
            if (bp) begin
                tx_out_ready = ~tx_out_ready;
                rx_out_ready = ~rx_out_ready;
            end else begin
                tx_out_ready = 1'b1;
                rx_out_ready = 1'b1;
            end
        end
    end

    always @(negedge clk) begin
        if (tx_out_valid && tx_out_ready && txc_n < 64) begin
            txc[txc_n] = tx_out_data;
            txl[txc_n] = tx_out_last;
            txc_n++;
        end
        if (rx_out_valid && rx_out_ready && rxc_n < 64) begin
            rxc[rxc_n] = rx_out_data;
            rxl[rxc_n] = rx_out_last;
            rxc_n++;
        end
    end

    task automatic check(input logic ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // bit-serial reference over pay[0..n-1]
    function automatic logic [15:0] ref_crc(input logic [7:0] cfg, input int n);
        logic [15:0] r, mask, poly;
        int          top;
        logic        fb;
        mask = cfg[4] ? 16'h00FF : 16'hFFFF;
        poly = cfg[4] ? 16'h0007 : 16'h1021;
        top  = cfg[4] ? 7 : 15;
        r    = cfg[5] ? mask : 16'h0000;
        for (int k = 0; k < n; k++) begin
            for (int j = 0; j < 8; j++) begin
                fb = r[top] ^ (cfg[6] ? pay[k][7-j] : pay[k][j]);
                r  = (r << 1) & mask;
                if (fb) r = r ^ poly;
            end
        end
        if (cfg[5]) r = ~r & mask;
        return r;
    endfunction

    task automatic build_ex(input logic [7:0] cfg, input int n);
        logic [15:0] f;
        for (int i = 0; i < n; i++) ex[i] = pay[i];
        ex_n = n;
        f = ref_crc(cfg, n);
        if (cfg[2]) begin
            if (cfg[4]) begin
                ex[n] = f[7:0];
                ex_n  = n + 1;
            end else begin
                ex[n]   = cfg[5] ? f[7:0]  : f[15:8];
                ex[n+1] = cfg[5] ? f[15:8] : f[7:0];
                ex_n    = n + 2;
            end
        end
    endtask

    task automatic cmp(input string req, input logic use_rx);
        int  cn;
        logic ok;
        logic [7:0] a, e;
        cn = use_rx ? rxc_n : txc_n;
        ok = (cn == ex_n);
        a  = '0;
        e  = '0;
        for (int i = 0; i < ex_n && i < cn; i++) begin
            logic [7:0] v;
            logic       l;
            v = use_rx ? rxc[i] : txc[i];
            l = use_rx ? rxl[i] : txl[i];
            if (v != ex[i] || l != (i == ex_n - 1)) begin
                if (ok) begin
                    a = v;
                    e = ex[i];
                end
                ok = 1'b0;
            end
        end
        check(ok, req, {cn[15:0], 8'h00, a}, {ex_n[15:0], 8'h00, e});
    endtask

    task automatic write_cfg(input logic [7:0] v);
        @(posedge clk); #1;
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic pulse_clr();
        @(posedge clk); #1;
        stat_clr = 1'b1;
        @(posedge clk); #1;
        stat_clr = 1'b0;
    endtask

    task automatic send_tx(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            tx_in_valid = 1'b1;
            tx_in_data  = pay[i];
            tx_in_last  = (i == n - 1);
            @(negedge clk);
            while (!tx_in_ready) @(negedge clk);
        end
        @(posedge clk); #1;
        tx_in_valid = 1'b0;
        tx_in_last  = 1'b0;
    endtask

    task automatic send_rx(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            rx_in_valid = 1'b1;
            rx_in_data  = rxin[i];
            rx_in_last  = (i == n - 1);
            @(negedge clk);
            while (!rx_in_ready) @(negedge clk);
        end
        @(posedge clk); #1;
        rx_in_valid = 1'b0;
        rx_in_last  = 1'b0;
    endtask

    task automatic settle();
        repeat (16) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load_digits();
        for (int i = 0; i < 9; i++) pay[i] = 8'h31 + 8'(i);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R13 watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(cfg_rdata == 8'h0C, "R1 cfg reset", cfg_rdata, 8'h0C);
        check(!crc_err && !tx_out_valid && !rx_out_valid, "R1 outputs idle",
              {crc_err, tx_out_valid, rx_out_valid}, 0);

        // R2 reserved bits
        write_cfg(8'hFF);
        @(negedge clk);
        check(cfg_rdata == 8'h7C, "R2 write all ones", cfg_rdata, 8'h7C);
        write_cfg(8'h83);
        @(negedge clk);
        check(cfg_rdata == 8'h00, "R2 reserved only", cfg_rdata, 8'h00);

        // table walk: transmit, then loop back into receive
        for (int v = 0; v < 8; v++) begin
            int n;
            n = int'(VECS[v].len);
            for (int i = 0; i < n; i++) pay[i] = VECS[v].data[31 - 8*i -: 8];
            write_cfg(VECS[v].cfg);
            bp = VECS[v].bp;
            txc_n = 0;
            send_tx(n);
            settle();
            build_ex(VECS[v].cfg, n);
            cmp("R3 R6 R13 tx frame", 1'b0);
            for (int i = 0; i < txc_n && i < 20; i++) rxin[i] = txc[i];
            rxc_n = 0;
            send_rx(txc_n);
            settle();
            build_ex(8'h00, n);
            cmp("R8 R13 rx strip", 1'b1);
            check(!crc_err, "R8 no error", crc_err, 0);
            bp = 1'b0;
        end

        // R4 golden 16-bit plain
        load_digits();
        write_cfg(8'h4C);
        txc_n = 0;
        send_tx(9);
        settle();
        check(txc_n == 11 && txc[9] == 8'h31 && txc[10] == 8'hC3, "R4 golden",
              {txc[9], txc[10]}, 16'h31C3);

        // R5 golden 8-bit
        write_cfg(8'h5C);
        txc_n = 0;
        send_tx(9);
        settle();
        check(txc_n == 10 && txc[9] == 8'hF4, "R5 golden", txc[9], 8'hF4);

        // R7 golden HDLC-style
        write_cfg(8'h6C);
        txc_n = 0;
        send_tx(9);
        settle();
        check(txc_n == 11 && txc[9] == 8'h4E && txc[10] == 8'hD6, "R7 golden",
              {txc[9], txc[10]}, 16'h4ED6);

        // R6 LSB-first differs from MSB-first and matches reference
        write_cfg(8'h0C);
        txc_n = 0;
        send_tx(9);
        settle();
        build_ex(8'h0C, 9);
        cmp("R6 lsb-first", 1'b0);
        check({txc[9], txc[10]} != 16'h31C3, "R6 order matters", {txc[9], txc[10]}, 16'h31C3);

        // R3 transmit append off
        for (int i = 0; i < 3; i++) pay[i] = 8'h10 + 8'(i);
        write_cfg(8'h08);
        txc_n = 0;
        send_tx(3);
        settle();
        build_ex(8'h08, 3);
        cmp("R3 no append", 1'b0);

        // R11 receive check off: all bytes forwarded
        write_cfg(8'h04);
        for (int i = 0; i < 3; i++) rxin[i] = pay[i];
        rxc_n = 0;
        send_rx(3);
        settle();
        build_ex(8'h00, 3);
        cmp("R11 passthrough", 1'b1);
        check(!crc_err, "R11 no error", crc_err, 0);

        // R9 mismatch, stickiness, clear by status pulse
        write_cfg(8'h0C);
        build_ex(8'h0C, 3);
        for (int i = 0; i < 5; i++) rxin[i] = ex[i];
        rxin[4] = rxin[4] ^ 8'h01;
        rxc_n = 0;
        send_rx(5);
        settle();
        check(crc_err, "R9 mismatch flagged", crc_err, 1);
        check(rxc_n == 3, "R9 check bytes withheld", rxc_n, 3);
        repeat (20) @(posedge clk);
        @(negedge clk);
        check(crc_err, "R9 sticky", crc_err, 1);
        pulse_clr();
        @(negedge clk);
        check(!crc_err, "R9 status clear", crc_err, 0);

        // R9 cleared by next frame
        send_rx(5);
        settle();
        check(crc_err, "R9 flagged again", crc_err, 1);
        rxin[4] = rxin[4] ^ 8'h01;
        rxc_n = 0;
        send_rx(5);
        settle();
        check(!crc_err, "R9 new frame clears", crc_err, 0);
        build_ex(8'h00, 3);
        cmp("R8 good after bad", 1'b1);

        // R10 short frame
        rxin[0] = 8'h5A;
        rxc_n = 0;
        send_rx(1);
        settle();
        check(crc_err, "R10 short flagged", crc_err, 1);
        check(rxc_n == 0, "R10 nothing forwarded", rxc_n, 0);
        pulse_clr();

        // R12 mid-frame configuration write
        for (int i = 0; i < 4; i++) pay[i] = 8'hC0 + 8'(i);
        txc_n = 0;
        fork
            send_tx(4);
            begin
                repeat (2) @(posedge clk);
                write_cfg(8'h1C);
            end
        join
        settle();
        check(cfg_rdata == 8'h1C, "R12 register updated", cfg_rdata, 8'h1C);
        build_ex(8'h0C, 4);
        cmp("R12 frame keeps old mode", 1'b0);
        txc_n = 0;
        send_tx(4);
        settle();
        build_ex(8'h1C, 4);
        cmp("R12 next frame new mode", 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule